// File: doc/BRIEF.md
# Configurable Watchdog Timer with Reset Pulse Output

This block is a watchdog that software reaches through a small indexed configuration port: an index byte selects a register, and a write strobe or a read strobe moves one data byte. A reload register holds an 8-bit timeout count, and writing it restarts the countdown, which is also how software feeds the watchdog. A control register selects seconds or minutes as the count unit, enables the watchdog, chooses a held-level or pulsed reset output with one of four pulse widths, and holds a sticky timeout flag that software clears by writing a one to it.

Time comes from an external millisecond strobe that is one clock cycle wide. An internal prescaler turns it into seconds or minutes and restarts on every reload. The countdown runs only while both the device enable and the watchdog enable are set. When the count reaches zero the block raises the timeout flag and pulls its active-low reset output low. In level mode the output stays low until the flag is cleared or the watchdog is disabled. In pulse mode it stays low for the selected number of milliseconds. A separate pin enable decides whether the output is driven at all.

Top module: `cfg_wdog_timer`

## Requirements
- R1: After reset every register reads 0, the live count is 0 and `wdt_rst_n` is 1.
- R2: A write to index 0xF6 loads the count with the written byte and restarts the prescaler. A read of 0xF6 returns the live count. A reload in the same cycle as an expiring tick wins, and no expiry happens.
- R3: While running, the count drops by exactly one every TICKS_PER_SEC millisecond strobes when index 0xF5 bit 3 is 0. It drops every TICKS_PER_SEC*SECS_PER_MIN strobes when bit 3 is 1.
- R4: The count and the prescaler hold unless index 0x30 bit 0 (device enable) and index 0xF5 bit 5 (watchdog enable) are both 1.
- R5: The strobe that takes the count from 1 to 0 sets index 0xF5 bit 6 and starts the reset output. A count of 0 never expires, and no further expiry happens until a reload.
- R6: Writing 1 to index 0xF5 bit 6 clears the timeout flag, and writing 0 to it leaves the flag unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R7: With index 0xF5 bit 4 = 0 (level mode), `wdt_rst_n` is low from expiry until the timeout flag is cleared.
- R8: With index 0xF5 bit 4 = 1 (pulse mode), `wdt_rst_n` is low from expiry until the W-th strobe after it. W is PW0, PW1, PW2 or PW3 for index 0xF5 bits 1:0 = 0, 1, 2, 3 (by default 1, 25, 125 and 5000 ms).
- R9: Clearing either enable releases `wdt_rst_n` at once, in level and in pulse mode. Enabling again does not bring back an earlier output.
- R10: `wdt_rst_n` is 1 whenever index 0xF0 bit 7 (pin enable) is 0. Setting the bit again while a level output is held drives the pin low once more.
- R11: A read strobe presents the selected register on `cfg_rdata` one cycle later. Unmapped indices read 0, and so do the unused bits (0x30 bits 7:1, 0xF0 bits 6:0, 0xF5 bits 7 and 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Read data, valid the cycle after `cfg_rd` |
| wdt_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
The assertions assume that reset is held from time zero for at least one edge and that every input is driven to a known value from the first edge on. They also assume that a register access lasts a single cycle, so each `cfg_wr` pulse counts as exactly one write. The bench changes inputs only on the falling clock edge and keeps every write and read strobe one cycle long. It lines a millisecond strobe up with a write only in the two deliberate same-cycle collisions, the clear against an expiry and the reload against an expiry. A small tick rate and small pulse widths keep the minute mode and the longest pulse within a short run.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

    localparam int CNT_W = 8;

    localparam logic [7:0] IDX_DEV_EN = 8'h30;
    localparam logic [7:0] IDX_PIN_EN = 8'hF0;
    localparam logic [7:0] IDX_CTRL   = 8'hF5;
    localparam logic [7:0] IDX_TIME   = 8'hF6;

    localparam int BIT_PIN_EN = 7;
    localparam int BIT_STS    = 6;
    localparam int BIT_EN     = 5;
    localparam int BIT_PULSE  = 4;
    localparam int BIT_UNIT   = 3;

    typedef struct packed {
        logic       unit_min;
        logic       pulse_mode;
        logic       wd_en;
        logic [1:0] width_sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_LEVEL = 2'd1,
        OUT_PULSE = 2'd2
    } out_state_t;

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.unit_min   = b[BIT_UNIT];
        c.pulse_mode = b[BIT_PULSE];
        c.wd_en      = b[BIT_EN];
        c.width_sel  = b[1:0];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c, input logic sts);
        logic [7:0] b;
        b            = '0;
        b[BIT_UNIT]  = c.unit_min;
        b[BIT_PULSE] = c.pulse_mode;
        b[BIT_EN]    = c.wd_en;
        b[BIT_STS]   = sts;
        b[1:0]       = c.width_sel;
        return b;
    endfunction

endpackage

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    input  logic             wr,
    input  logic             rd,
    input  logic             expire,
    input  logic [CNT_W-1:0] count,
    output logic [7:0]       rdata_q,
    output logic             dev_en_q,
    output logic             pin_en_q,
    output ctrl_t            ctrl_q,
    output logic             sts_q,
    output logic             reload,
    output logic [CNT_W-1:0] reload_val
);

    logic [7:0] rd_mux;

    assign reload     = wr && (idx == IDX_TIME);
    assign reload_val = wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_en_q <= 1'b0;
            pin_en_q <= 1'b0;
            ctrl_q   <= '0;
        end else if (wr) begin
            case (idx)
                IDX_DEV_EN: dev_en_q <= wdata[0];
                IDX_PIN_EN: pin_en_q <= wdata[BIT_PIN_EN];
                IDX_CTRL:   ctrl_q   <= ctrl_from_byte(wdata);
                default: ;
            endcase
        end
    end

    // expiry has priority over a write-one clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= 1'b0;
        end else if (expire) begin
            sts_q <= 1'b1;
        end else if (wr && idx == IDX_CTRL && wdata[BIT_STS]) begin
            sts_q <= 1'b0;
        end
    end

    always_comb begin
        case (idx)
            IDX_DEV_EN: rd_mux = {7'b0, dev_en_q};
            IDX_PIN_EN: rd_mux = {pin_en_q, 7'b0};
            IDX_CTRL:   rd_mux = ctrl_to_byte(ctrl_q, sts_q);
            IDX_TIME:   rd_mux = 8'(count);
            default:    rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= rd_mux;
        end
    end

endmodule

// File: rtl/wdg_counter.sv
`timescale 1ns/1ps
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SECS_PER_MIN  = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ms_tick,
    input  logic             unit_min,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);

    localparam int MIN_TICKS = TICKS_PER_SEC * SECS_PER_MIN;
    localparam int PRE_W     = (MIN_TICKS > 2) ? $clog2(MIN_TICKS) : 1;
    localparam logic [PRE_W-1:0] SEC_LAST = PRE_W'(TICKS_PER_SEC - 1);
    localparam logic [PRE_W-1:0] MIN_LAST = PRE_W'(MIN_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;
    logic             step;
    logic             wrap;

    assign last = unit_min ? MIN_LAST : SEC_LAST;
    // >= keeps a unit change mid-count from overrunning the shorter limit
    assign wrap = (pre_q >= last);
    assign step = run && ms_tick && !reload && (count_q != '0);
    assign expire = step && wrap && (count_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            pre_q   <= '0;
        end else if (reload) begin
            count_q <= reload_val;
            pre_q   <= '0;
        end else if (step) begin
            if (wrap) begin
                pre_q   <= '0;
                count_q <= count_q - CNT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/wdg_output.sv
`timescale 1ns/1ps
module wdg_output
    import wdg_pkg::*;
#(
    parameter int PW0 = 1,
    parameter int PW1 = 25,
    parameter int PW2 = 125,
    parameter int PW3 = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       expire,
    input  logic       ms_tick,
    input  logic       pulse_mode,
    input  logic [1:0] width_sel,
    input  logic       sts,
    input  logic       pin_en,
    output logic       pin_n
);

    localparam int PW_MAX = (PW0 > PW1 ? PW0 : PW1) > (PW2 > PW3 ? PW2 : PW3)
                          ? (PW0 > PW1 ? PW0 : PW1) : (PW2 > PW3 ? PW2 : PW3);
    localparam int PW_W   = $clog2(PW_MAX + 1);

    out_state_t      state_q;
    logic [PW_W-1:0] left_q;
    logic [PW_W-1:0] width;
    logic            asserted;

    always_comb begin
        case (width_sel)
            2'd0:    width = PW_W'(PW0);
            2'd1:    width = PW_W'(PW1);
            2'd2:    width = PW_W'(PW2);
            default: width = PW_W'(PW3);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_IDLE;
            left_q  <= '0;
        end else if (!active) begin
            state_q <= OUT_IDLE;
            left_q  <= '0;
        end else if (expire) begin
            if (pulse_mode) begin
                state_q <= OUT_PULSE;
                left_q  <= width;
            end else begin
                state_q <= OUT_LEVEL;
            end
        end else begin
            case (state_q)
                OUT_LEVEL: if (!sts) state_q <= OUT_IDLE;
                OUT_PULSE: begin
                    if (ms_tick) begin
                        if (left_q <= PW_W'(1)) begin
                            state_q <= OUT_IDLE;
                            left_q  <= '0;
                        end else begin
                            left_q <= left_q - PW_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // enable and flag act combinationally so a disable or clear releases at once
    assign asserted = active && (((state_q == OUT_LEVEL) && sts) || (state_q == OUT_PULSE));
    assign pin_n    = !(asserted && pin_en);

endmodule

// File: rtl/cfg_wdog_timer.sv
`timescale 1ns/1ps
module cfg_wdog_timer
    import wdg_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SECS_PER_MIN  = 60,
    parameter int PW0 = 1,
    parameter int PW1 = 25,
    parameter int PW2 = 125,
    parameter int PW3 = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic [7:0] cfg_idx,
    input  logic [7:0] cfg_wdata,
    input  logic       cfg_wr,
    input  logic       cfg_rd,
    output logic [7:0] cfg_rdata,
    output logic       wdt_rst_n
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_val;
    logic             reload_s;
    logic             expire_s;
    logic             dev_en;
    logic             pin_en;
    logic             sts_q;
    logic             wd_en;
    logic             run;
    ctrl_t            ctrl;

    assign wd_en = ctrl.wd_en;
    assign run   = dev_en && wd_en;

    wdg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .idx        (cfg_idx),
        .wdata      (cfg_wdata),
        .wr         (cfg_wr),
        .rd         (cfg_rd),
        .expire     (expire_s),
        .count      (count_q),
        .rdata_q    (cfg_rdata),
        .dev_en_q   (dev_en),
        .pin_en_q   (pin_en),
        .ctrl_q     (ctrl),
        .sts_q      (sts_q),
        .reload     (reload_s),
        .reload_val (reload_val)
    );

    wdg_counter #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SECS_PER_MIN  (SECS_PER_MIN)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ms_tick    (ms_tick),
        .unit_min   (ctrl.unit_min),
        .reload     (reload_s),
        .reload_val (reload_val),
        .count_q    (count_q),
        .expire     (expire_s)
    );

    wdg_output #(
        .PW0 (PW0),
        .PW1 (PW1),
        .PW2 (PW2),
        .PW3 (PW3)
    ) u_output (
        .clk        (clk),
        .rst        (rst),
        .active     (run),
        .expire     (expire_s),
        .ms_tick    (ms_tick),
        .pulse_mode (ctrl.pulse_mode),
        .width_sel  (ctrl.width_sel),
        .sts        (sts_q),
        .pin_en     (pin_en),
        .pin_n      (wdt_rst_n)
    );

endmodule

// File: rtl/wdg_checker.sv
`timescale 1ns/1ps
module wdg_checker
    import wdg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [7:0]       cfg_idx,
    input logic [7:0]       cfg_wdata,
    input logic             cfg_wr,
    input logic [CNT_W-1:0] count_q,
    input logic             reload_s,
    input logic             dev_en,
    input logic             wd_en,
    input logic             sts_q,
    input logic             wdt_rst_n
);

    p_reload_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_idx == IDX_TIME) |=> (count_q == $past(cfg_wdata)));

    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(reload_s) && count_q != $past(count_q)) |-> (count_q == $past(count_q) - CNT_W'(1)));

    p_hold_when_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        (!(dev_en && wd_en) && !reload_s) |=> (count_q == $past(count_q)));

    p_expiry_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && $past(count_q) != '0 && !$past(reload_s)) |-> sts_q);

    p_flag_clear_by_write_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(sts_q) && !sts_q) |-> ($past(cfg_wr) && $past(cfg_idx) == IDX_CTRL && $past(cfg_wdata[BIT_STS])));

    p_disable_releases_r9: assert property (@(posedge clk) disable iff (rst)
        (!dev_en || !wd_en) |-> wdt_rst_n);

endmodule

bind cfg_wdog_timer wdg_checker u_wdg_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_wr    (cfg_wr),
    .count_q   (count_q),
    .reload_s  (reload_s),
    .dev_en    (dev_en),
    .wd_en     (wd_en),
    .sts_q     (sts_q),
    .wdt_rst_n (wdt_rst_n)
);

// File: tb/test_cfg_wdog_timer.sv
`timescale 1ns/1ps
module test_cfg_wdog_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic [7:0] cfg_idx = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cfg_wr = 1'b0;
    logic       cfg_rd = 1'b0;
    logic [7:0] cfg_rdata;
    logic       wdt_rst_n;

    int total = 0;
    int bad = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;

    always #2.5 clk = ~clk;

    // 4 strobes per second, 3 seconds per minute, widths 1/3/5/9
    cfg_wdog_timer #(
        .TICKS_PER_SEC (4),
        .SECS_PER_MIN  (3),
        .PW0 (1), .PW1 (3), .PW2 (5), .PW3 (9)
    ) i_cfg_wdog_timer (
        .clk       (clk),
        .rst       (rst),
        .ms_tick   (ms_tick),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_rdata (cfg_rdata),
        .wdt_rst_n (wdt_rst_n)
    );

    // monitor: read data is due one cycle after the strobe
    always @(posedge clk) rd_d <= cfg_rd;

    always @(negedge clk) begin
        if (rd_d) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected read data got=%h expected=none", cfg_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (cfg_rdata !== e) begin
                    bad++;
                    $display("FAIL %s got=%h expected=%h", t, cfg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_idx = idx; cfg_wdata = data; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_idx = idx; cfg_wdata = data; cfg_wr = 1'b1; ms_tick = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; ms_tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cfg_idx = idx; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic check_pin(input logic exp, input string tag);
        total++;
        if (wdt_rst_n !== exp) begin
            bad++;
            $display("FAIL %s wdt_rst_n got=%b expected=%b", tag, wdt_rst_n, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_pin(1'b1, "R1 pin after reset");
        rd(8'h30, 8'h00, "R1 device enable after reset");
        rd(8'hF0, 8'h00, "R1 pin enable after reset");
        rd(8'hF5, 8'h00, "R1 control after reset");
        rd(8'hF6, 8'h00, "R1 count after reset");

        // R2 reload, R4 hold while device disabled
        wr(8'hF6, 8'd3);
        rd(8'hF6, 8'd3, "R2 reload value");
        tick(8);
        rd(8'hF6, 8'd3, "R4 count held with device disabled");

        wr(8'h30, 8'h01);
        wr(8'hF0, 8'h80);
        wr(8'hF5, 8'h20);
        rd(8'h30, 8'h01, "R11 device enable readback");
        rd(8'hF0, 8'h80, "R11 pin enable readback");
        rd(8'hF5, 8'h20, "R11 control readback");

        // R3 seconds unit
        tick(3);
        rd(8'hF6, 8'd3, "R3 no step before full second");
        tick(1);
        rd(8'hF6, 8'd2, "R3 step after one second");

        // R2 keepalive restarts prescaler
        tick(2);
        wr(8'hF6, 8'd3);
        tick(3);
        rd(8'hF6, 8'd3, "R2 prescaler restarted by reload");
        tick(1);
        rd(8'hF6, 8'd2, "R2 step after full second from reload");

        // R4 hold while watchdog enable clear
        wr(8'hF5, 8'h00);
        tick(8);
        rd(8'hF6, 8'd2, "R4 count held with watchdog disabled");
        wr(8'hF5, 8'h20);
        tick(7);
        check_pin(1'b1, "R5 no output before expiry");
        rd(8'hF6, 8'd1, "R3 count before expiry");
        tick(1);
        check_pin(1'b0, "R7 level output at expiry");
        rd(8'hF5, 8'h60, "R5 flag set at expiry");
        tick(20);
        rd(8'hF6, 8'd0, "R5 count stays at zero");
        check_pin(1'b0, "R7 level held");
        wr(8'hF5, 8'h20);
        rd(8'hF5, 8'h60, "R6 writing zero keeps flag");
        check_pin(1'b0, "R6 level still held");
        wr(8'hF5, 8'h60);
        rd(8'hF5, 8'h20, "R6 write one clears flag");
        check_pin(1'b1, "R7 released by clear");

        // R10 pin gating, R9 device disable
        wr(8'hF6, 8'd1);
        tick(4);
        check_pin(1'b0, "R7 second expiry");
        wr(8'hF0, 8'h00);
        check_pin(1'b1, "R10 pin disabled");
        rd(8'hF0, 8'h00, "R10 pin enable cleared");
        wr(8'hF0, 8'h80);
        check_pin(1'b0, "R10 pin enabled again");
        wr(8'h30, 8'h00);
        check_pin(1'b1, "R9 device disable releases");
        rd(8'hF5, 8'h60, "R9 flag kept across disable");
        wr(8'h30, 8'h01);
        check_pin(1'b1, "R9 no return after re-enable");
        wr(8'hF5, 8'h60);

        // R8 pulse widths
        wr(8'hF5, 8'h31);
        wr(8'hF6, 8'd1);
        tick(4);
        check_pin(1'b0, "R8 pulse width 3 start");
        rd(8'hF5, 8'h71, "R5 flag in pulse mode");
        tick(2);
        check_pin(1'b0, "R8 pulse width 3 held");
        tick(1);
        check_pin(1'b1, "R8 pulse width 3 end");
        wr(8'hF5, 8'h71);
        rd(8'hF5, 8'h31, "R6 clear in pulse mode");

        wr(8'hF5, 8'h33);
        wr(8'hF6, 8'd1);
        tick(4);
        tick(8);
        check_pin(1'b0, "R8 pulse width 9 held");
        tick(1);
        check_pin(1'b1, "R8 pulse width 9 end");

        wr(8'hF5, 8'h30);
        wr(8'hF6, 8'd1);
        tick(4);
        check_pin(1'b0, "R8 pulse width 1 start");
        tick(1);
        check_pin(1'b1, "R8 pulse width 1 end");

        wr(8'hF5, 8'h32);
        wr(8'hF6, 8'd1);
        tick(4);
        tick(2);
        check_pin(1'b0, "R8 pulse width 5 held");
        wr(8'hF5, 8'h12);
        check_pin(1'b1, "R9 watchdog disable cuts pulse");
        rd(8'hF5, 8'h52, "R9 control after disable");

        // R3 minute unit: 12 strobes per step
        wr(8'hF5, 8'h68);
        rd(8'hF5, 8'h28, "R6 clear while switching to minutes");
        wr(8'hF6, 8'd2);
        tick(11);
        rd(8'hF6, 8'd2, "R3 no step before full minute");
        tick(1);
        rd(8'hF6, 8'd1, "R3 step after one minute");
        tick(11);
        check_pin(1'b1, "R5 no minute expiry early");
        tick(1);
        check_pin(1'b0, "R5 minute expiry");
        rd(8'hF5, 8'h68, "R5 flag after minute expiry");
        wr(8'hF5, 8'h68);

        // R5 zero count never expires
        wr(8'hF6, 8'd0);
        tick(30);
        check_pin(1'b1, "R5 zero count no output");
        rd(8'hF5, 8'h28, "R5 zero count no flag");

        // R6 expiry against clear in the same cycle
        wr(8'hF5, 8'h20);
        wr(8'hF6, 8'd1);
        tick(3);
        wr_tick(8'hF5, 8'h60);
        rd(8'hF5, 8'h60, "R6 expiry wins over clear");
        check_pin(1'b0, "R6 output after collision");
        wr(8'hF5, 8'h60);
        check_pin(1'b1, "R7 released after collision");

        // R2 reload against expiry in the same cycle
        wr(8'hF6, 8'd1);
        tick(3);
        wr_tick(8'hF6, 8'd2);
        rd(8'hF6, 8'd2, "R2 reload wins over expiry");
        rd(8'hF5, 8'h20, "R2 no flag on reload collision");
        check_pin(1'b1, "R2 no output on reload collision");

        // R11 unmapped and unused bits
        rd(8'h55, 8'h00, "R11 unmapped index");
        wr(8'hF5, 8'hFF);
        rd(8'hF5, 8'h3B, "R11 control unused bits");
        wr(8'hF0, 8'h7F);
        rd(8'hF0, 8'h00, "R11 pin enable unused bits");
        wr(8'h30, 8'hFE);
        rd(8'h30, 8'h00, "R11 device enable unused bits");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R11 reads outstanding got=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule